// File: doc/BRIEF.md
# Input-Loss Free-Run Source Guard

This block sits at the front of a panel timing engine. It watches the incoming video timing and decides where the engine takes its line and frame timing from: the incoming stream or an internal raster that runs by itself. It watches the data-enable signal whenever data-enable is active. It watches vertical sync only when the board strap selects sync-only operation and no data-enable edge has been seen. If the watched signal stays constant for too long, the guard switches to an internal 60 Hz raster and raises a blanking flag, so that downstream logic drives pixel data low.

The timeout is counted in frames of the internal raster, so it takes the same time whether or not any input is present. A rising edge on the watched signal ends free-run at once, and the control strobes follow the input again from that cycle. The blanking flag stays up until the next frame start taken from the input, so pixel data returns one frame after the control timing does. A board strap can disable the whole free-run function.

The raster sizes and the timeout are parameters. The defaults give the standard 60 Hz totals: 1688 clocks by 1066 lines for the two narrower resolution codes, and 2160 clocks by 1250 lines for the widest.

Top module: `fr_source_guard`

## Requirements
- R1: After reset, free_run_o, data_blank_o and frame_stb_o are 0, and the frame-timeout count is cleared.
- R2: In sync-only operation with no data-enable activity, frame_stb_o pulses for one cycle, one clock after each rising edge of vsync_i. line_stb_o pulses every H_STD clocks, counted from that edge.
- R3: Once data_enable_i has a rising edge, data-enable is watched and vsync_i activity is no longer needed, even when sync_only_i is 1. line_stb_o pulses one clock after every data-enable rising edge. frame_stb_o pulses only for the first rising edge after data-enable has been absent for more than twice the last measured line period.
- R4: With fr_enable_i at 1, free_run_o rises when the watched signal has not changed during 6 consecutive internal frame ends. It never rises sooner than 5 internal frame periods after the last change, and it rises only at an internal frame end.
- R5: In free-run, frame_stb_o and line_stb_o come from the internal raster. For res_mode_i values 0, 1 and 3 a line is H_STD clocks and a frame is V_STD lines. For res_mode_i value 2 a line is H_WIDE clocks and a frame is V_WIDE lines.
- R6: data_blank_o is 1 whenever free_run_o is 1.
- R7: In free-run, a rising edge on the watched signal clears free_run_o one clock later. data_blank_o stays 1 until the next frame start taken from the input, and it falls in the same cycle as that frame's frame_stb_o.
- R8: When sync_only_i is 0, vsync_i has no effect: its edges neither hold off the timeout nor end free-run.
- R9: When fr_enable_i is 0, free_run_o and data_blank_o are 0 one clock later and stay 0, however long the input is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| data_enable_i | input | 1 | Incoming data-enable |
| vsync_i | input | 1 | Incoming vertical sync, active high |
| sync_only_i | input | 1 | Board strap: 1 allows sync-only timing when data-enable is idle |
| fr_enable_i | input | 1 | Board strap: 1 enables the free-run function |
| res_mode_i | input | 2 | Resolution code; 2 selects the wide raster, other values the standard one |
| line_stb_o | output | 1 | One-cycle line strobe for the timing engine |
| frame_stb_o | output | 1 | One-cycle frame strobe for the timing engine |
| data_blank_o | output | 1 | 1 forces output pixel data low |
| free_run_o | output | 1 | 1 while the internal raster is in control |

## Verification
The first pattern is periodic vsync pulses with data-enable held low. This separates sync-driven framing and the resynchronised line strobe from the free-running raster. Stopping the pulses then brackets the timeout between five and six internal frames. The second pattern is line bursts of data-enable, grouped into frames by long gaps, with vsync held still while the sync strap is set. A design that kept watching vsync would drop into free-run during this pattern, and the strobe counts show whether the vertical-blank detection starts a frame only on the first line. A third pattern toggles vsync while the sync strap is clear and data-enable is lost; this shows that vsync is truly ignored. Recovery is tried from both sources, and in each case the one-frame gap between the return of the control strobes and the release of blanking is checked. The raster periods in free-run are compared against expected frame intervals for both resolution classes.

// File: rtl/fr_guard_pkg.sv
package fr_guard_pkg;

    // Resolution selector codes; only the widest one changes the raster.
    typedef enum logic [1:0] {
        RES_NARROW = 2'd0,
        RES_MEDIUM = 2'd1,
        RES_WIDE   = 2'd2,
        RES_SPARE  = 2'd3
    } res_mode_e;

    function automatic logic is_wide(input logic [1:0] mode);
        return mode == 2'(RES_WIDE);
    endfunction

endpackage

// File: rtl/fr_raster.sv
// Internal free-running raster: a pixel counter and a line counter.
module fr_raster #(
    parameter int H_STD  = 1688,
    parameter int V_STD  = 1066,
    parameter int H_WIDE = 2160,
    parameter int V_WIDE = 1250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wide_i,
    input  logic restart_i,
    output logic line_end_o,
    output logic frame_end_o
);
    localparam int H_MAX = (H_WIDE > H_STD) ? H_WIDE : H_STD;
    localparam int V_MAX = (V_WIDE > V_STD) ? V_WIDE : V_STD;
    localparam int HW    = $clog2(H_MAX);
    localparam int VW    = $clog2(V_MAX);
    localparam logic [HW-1:0] H_END_STD  = HW'(H_STD - 1);
    localparam logic [HW-1:0] H_END_WIDE = HW'(H_WIDE - 1);
    localparam logic [VW-1:0] V_END_STD  = VW'(V_STD - 1);
    localparam logic [VW-1:0] V_END_WIDE = VW'(V_WIDE - 1);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } raster_t;

    raster_t q, d;
    logic [HW-1:0] h_end;
    logic [VW-1:0] v_end;

    always_comb begin
        h_end       = wide_i ? H_END_WIDE : H_END_STD;
        v_end       = wide_i ? V_END_WIDE : V_END_STD;
        // ">=" lets a mode switch to a shorter raster wrap cleanly
        line_end_o  = (q.h >= h_end);
        frame_end_o = line_end_o && (q.v >= v_end);
        d = q;
        if (restart_i) begin
            d.h = '0;
            d.v = '0;
        end else if (line_end_o) begin
            d.h = '0;
            d.v = frame_end_o ? '0 : q.v + 1'b1;
        end else begin
            d.h = q.h + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R5
    raster_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.h <= HW'(H_MAX - 1)) && (q.v <= VW'(V_MAX - 1)));

endmodule

// File: rtl/fr_de_track.sv
// Measures the data-enable line period and flags a vertical blank once
// data-enable has been absent for more than two line periods.
module fr_de_track #(
    parameter int GAP_W = 14
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic de_rise_i,
    output logic vblank_o
);
    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] period;
        logic             vblank;
    } track_t;

    track_t q, d;
    logic [GAP_W-1:0] gap_inc;

    always_comb begin
        gap_inc = (q.gap == '1) ? q.gap : q.gap + 1'b1;
        d = q;
        if (de_rise_i) begin
            d.gap    = '0;
            d.vblank = 1'b0;
            // the line before a blank is not a valid period sample
            if (!q.vblank) d.period = gap_inc;
        end else begin
            d.gap = gap_inc;
            if ((q.period != '0) && ({1'b0, gap_inc} > {q.period, 1'b0}))
                d.vblank = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.gap    <= '0;
            q.period <= '0;
            q.vblank <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign vblank_o = q.vblank;

    // R3
    vblank_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        de_rise_i |=> !vblank_o);

endmodule

// File: rtl/fr_loss_timer.sv
// Counts internal frame ends since the last change of the watched signal.
module fr_loss_timer #(
    parameter int TIMEOUT_FRAMES = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic clear_i,
    input  logic frame_end_i,
    output logic expire_o
);
    localparam int CW = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_FRAMES);

    typedef struct packed {
        logic [CW-1:0] idle;
    } timer_t;

    timer_t q, d;

    always_comb begin
        d = q;
        expire_o = 1'b0;
        if (clear_i) begin
            d.idle = '0;
        end else if (frame_end_i) begin
            if (q.idle == LIMIT) expire_o = enable_i;
            else                 d.idle   = q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R4
    idle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.idle <= LIMIT);

endmodule

// File: rtl/fr_source_guard.sv
module fr_source_guard
    import fr_guard_pkg::*;
#(
    parameter int H_STD          = 1688,
    parameter int V_STD          = 1066,
    parameter int H_WIDE         = 2160,
    parameter int V_WIDE         = 1250,
    parameter int TIMEOUT_FRAMES = 5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       data_enable_i,
    input  logic       vsync_i,
    input  logic       sync_only_i,
    input  logic       fr_enable_i,
    input  logic [1:0] res_mode_i,
    output logic       line_stb_o,
    output logic       frame_stb_o,
    output logic       data_blank_o,
    output logic       free_run_o
);
    localparam int H_MAX = (H_WIDE > H_STD) ? H_WIDE : H_STD;
    localparam int GAP_W = $clog2(H_MAX * 4);

    typedef struct packed {
        logic de;
        logic vs;
        logic de_seen;
        logic freerun;
        logic blank;
        logic line_stb;
        logic frame_stb;
    } guard_t;

    guard_t q, d;

    logic de_rise, de_chg, vs_rise, vs_chg;
    logic de_mode, mon_chg, rec_w;
    logic in_line, in_frame;
    logic int_line_end, int_frame_end;
    logic restart_w, vblank_w, expire_w, timer_en;

    // edge detection on the raw inputs
    assign de_rise = data_enable_i & ~q.de;
    assign de_chg  = data_enable_i ^ q.de;
    assign vs_rise = vsync_i & ~q.vs;
    assign vs_chg  = vsync_i ^ q.vs;

    // data-enable wins whenever it is active
    assign de_mode  = ~sync_only_i | q.de_seen | de_rise;
    assign mon_chg  = de_mode ? de_chg : vs_chg;
    assign rec_w    = de_rise | (sync_only_i & ~q.de_seen & vs_rise);
    assign in_line  = de_mode ? de_rise : int_line_end;
    assign in_frame = de_mode ? (de_rise & vblank_w) : vs_rise;

    assign timer_en  = fr_enable_i & ~q.freerun;
    assign restart_w = ~d.freerun & ~de_mode & vs_rise;

    fr_raster #(
        .H_STD (H_STD),
        .V_STD (V_STD),
        .H_WIDE(H_WIDE),
        .V_WIDE(V_WIDE)
    ) i_raster (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wide_i     (is_wide(res_mode_i)),
        .restart_i  (restart_w),
        .line_end_o (int_line_end),
        .frame_end_o(int_frame_end)
    );

    fr_de_track #(
        .GAP_W(GAP_W)
    ) i_de_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .de_rise_i(de_rise),
        .vblank_o (vblank_w)
    );

    fr_loss_timer #(
        .TIMEOUT_FRAMES(TIMEOUT_FRAMES)
    ) i_loss_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (timer_en),
        .clear_i    (mon_chg | ~timer_en),
        .frame_end_i(int_frame_end),
        .expire_o   (expire_w)
    );

    always_comb begin
        d    = q;
        d.de = data_enable_i;
        d.vs = vsync_i;
        if (de_rise) d.de_seen = 1'b1;
        if (!fr_enable_i) begin
            d.freerun = 1'b0;
            d.blank   = 1'b0;
        end else if (q.freerun) begin
            if (rec_w) d.freerun = 1'b0;   // blank waits for the next frame
        end else if (expire_w) begin
            d.freerun = 1'b1;
            d.blank   = 1'b1;
            d.de_seen = 1'b0;
        end else if (q.blank && in_frame) begin
            d.blank = 1'b0;
        end
        d.line_stb  = d.freerun ? int_line_end  : in_line;
        d.frame_stb = d.freerun ? int_frame_end : in_frame;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign line_stb_o   = q.line_stb;
    assign frame_stb_o  = q.frame_stb;
    assign data_blank_o = q.blank;
    assign free_run_o   = q.freerun;

    // R6
    blank_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.freerun |-> q.blank);

    // R4
    entry_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.freerun) |-> $past(int_frame_end));

    // R7
    exit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.freerun) |-> $past(rec_w || !fr_enable_i));

    // R9
    strap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fr_enable_i |=> (!q.freerun && !q.blank));

    // R7
    blank_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.blank) |-> (q.frame_stb || !$past(fr_enable_i)));

endmodule

// File: tb/test_fr_source_guard.sv
module test_fr_source_guard;
    localparam int HS = 10;
    localparam int VS = 4;
    localparam int HW = 12;
    localparam int VW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic de = 1'b0;
    logic vsync = 1'b0;
    logic sync_only = 1'b1;
    logic fr_en = 1'b1;
    logic [1:0] res_mode = 2'd0;
    logic line_stb, frame_stb, blank, freerun;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int line_cnt = 0;
    int frame_cnt = 0;
    int last_fr = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    fr_source_guard #(
        .H_STD(HS), .V_STD(VS), .H_WIDE(HW), .V_WIDE(VW), .TIMEOUT_FRAMES(5)
    ) i_fr_source_guard (
        .clk_i(clk), .rst_ni(rst_n), .data_enable_i(de), .vsync_i(vsync),
        .sync_only_i(sync_only), .fr_enable_i(fr_en), .res_mode_i(res_mode),
        .line_stb_o(line_stb), .frame_stb_o(frame_stb),
        .data_blank_o(blank), .free_run_o(freerun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_frame();
        do tick(); while (!frame_stb);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) tick();
    endtask

    always @(posedge clk) cyc++;

    // monitor: counts strobes and pops expected frame intervals (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (line_stb) line_cnt++;
            if (frame_stb) begin
                frame_cnt++;
                if (exp_q.size() > 0) chk("R5 frame interval", cyc - last_fr, exp_q.pop_front());
                last_fr = cyc;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int l0, f0;
        tick(5);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 free_run", freerun, 0);
        chk("R1 blank", blank, 0);
        chk("R1 frame_stb", frame_stb, 0);

        // R2 sync-only framing
        l0 = 0;
        for (int i = 0; i < 6; i++) begin
            vsync = 1'b1;
            tick();
            chk("R2 frame_stb after vsync rise", frame_stb, 1);
            if (i == 4) l0 = line_cnt;
            if (i == 5) chk("R2 lines per sync frame", line_cnt - l0, VS);
            vsync = 1'b0;
            tick(39);
        end
        chk("R2 no free-run while vsync active", freerun, 0);

        // R4 timeout window after vsync stops
        tick(150);
        chk("R4 not before five frames", freerun, 0);
        tick(60);
        chk("R4 free-run entered", freerun, 1);
        chk("R6 blank in free-run", blank, 1);

        // R5 standard raster
        wait_frame();
        exp_q.push_back(HS * VS); exp_q.push_back(HS * VS); exp_q.push_back(HS * VS);
        drain();
        wait_frame();
        l0 = line_cnt;
        wait_frame();
        chk("R5 lines per standard frame", line_cnt - l0, VS);

        // R5 wide raster
        res_mode = 2'd2;
        wait_frame();
        wait_frame();
        exp_q.push_back(HW * VW); exp_q.push_back(HW * VW);
        drain();
        wait_frame();
        l0 = line_cnt;
        wait_frame();
        chk("R5 lines per wide frame", line_cnt - l0, VW);
        res_mode = 2'd0;
        wait_frame();
        wait_frame();

        // R7 recovery through vsync
        vsync = 1'b1;
        tick();
        chk("R7 free-run cleared", freerun, 0);
        chk("R7 blank held", blank, 1);
        chk("R7 frame_stb at recovery", frame_stb, 1);
        vsync = 1'b0;
        tick(20);
        chk("R7 blank held mid-frame", blank, 1);
        tick(19);
        vsync = 1'b1;
        tick();
        chk("R7 blank released at next frame", blank, 0);
        chk("R7 frame_stb with release", frame_stb, 1);
        vsync = 1'b0;
        tick(3);

        // R3 data-enable priority with sync strap set, vsync still
        f0 = frame_cnt;
        l0 = line_cnt;
        for (int fr = 0; fr < 6; fr++) begin
            for (int ln = 0; ln < 4; ln++) begin
                de = 1'b1;
                tick();
                if (fr == 0 && ln == 0) chk("R3 frame_stb on first line", frame_stb, 1);
                if (fr == 0 && ln == 1) begin
                    chk("R3 no frame_stb on second line", frame_stb, 0);
                    chk("R3 line_stb on second line", line_stb, 1);
                end
                tick(5);
                de = 1'b0;
                tick(4);
            end
            tick(30);
        end
        chk("R3 no free-run while DE active", freerun, 0);
        chk("R3 frame count", frame_cnt - f0, 6);
        chk("R3 line count", line_cnt - l0, 24);

        // R8 vsync ignored when sync strap clear
        sync_only = 1'b0;
        for (int t = 0; t < 8; t++) begin
            vsync = ~vsync;
            tick(20);
        end
        chk("R8 vsync does not hold off timeout yet", freerun, 0);
        for (int t = 0; t < 4; t++) begin
            vsync = ~vsync;
            tick(20);
        end
        chk("R8 free-run despite vsync edges", freerun, 1);
        for (int t = 0; t < 4; t++) begin
            vsync = ~vsync;
            tick(20);
        end
        chk("R8 vsync does not end free-run", freerun, 1);

        // R7 recovery through data-enable
        de = 1'b1;
        tick();
        chk("R7 DE recovery clears free-run", freerun, 0);
        chk("R7 DE recovery keeps blank", blank, 1);
        chk("R7 DE recovery frame_stb", frame_stb, 1);
        tick(5);
        de = 1'b0;
        tick(4);
        for (int ln = 0; ln < 3; ln++) begin
            de = 1'b1;
            tick(6);
            de = 1'b0;
            tick(4);
        end
        chk("R7 blank held through frame", blank, 1);
        tick(30);
        de = 1'b1;
        tick();
        chk("R7 DE next frame releases blank", blank, 0);
        tick(5);
        de = 1'b0;

        // R9 free-run disable strap
        tick(280);
        chk("R4 free-run after DE loss", freerun, 1);
        fr_en = 1'b0;
        tick();
        chk("R9 strap off clears free-run", freerun, 0);
        chk("R9 strap off clears blank", blank, 0);
        tick(300);
        chk("R9 no free-run while disabled", freerun, 0);
        chk("R9 no blank while disabled", blank, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule